// File: doc/BRIEF.md
# Socket Interrupt Flag and Routing Unit

This block gathers interrupt events for a removable-card socket controller. Each event arrives as a one-cycle pulse and sets a sticky status flag, which stays set until software clears it. Two banks of flags exist. The first bank holds events for older-style cards, plus the socket's power-up-complete event. The second bank holds socket events for newer-style cards. Every flag has its own enable (mask) bit. The card's functional interrupt is a level input. It has no mask and always reaches its output line.

Masked flags from both banks are combined into a card-status-change interrupt. The functional interrupt drives a second line. A tie bit in the control register moves the status-change interrupt onto the functional line, so that a system with a single line can use both. Software reaches flags, masks and control through a small synchronous register port. Older-style flags clear either when read or when written with 1; a control bit chooses which. Newer-style flags clear only when written with 1.

Top module: `sock_irq_unit`

## Requirements
- R1: Reset state. After reset every flag and mask is 0 and the tie bit is 0. The clear-mode bit (control register bit 2) is 0, which selects clear-on-read. rdata is 0, csc_irq is low, and func_irq follows card_func.
- R2: Flag capture. A one-cycle pulse on leg_evt[i], pwr_done or new_evt[j] sets the matching flag at the next clock edge, and the flag stays set until cleared. Older-style flags read at address 0: leg_evt in bits 2:0 and power-up-complete in bit 3. Newer-style flags read at address 2, bits 3:0. A flag never sets without its event.
- R3: Set wins. When an event and a clear of the same flag happen in the same cycle, the flag is set afterwards. This holds for clear-on-read and for write-1 clears.
- R4: Status-change line. With tie at 0, csc_irq is high exactly when some flag in either bank is set and its mask bit is 1. Older-style masks are at address 1, bits 3:0. Newer-style masks are at address 3, bits 3:0.
- R5: Functional line and tie. func_irq is card_func OR (tie AND any masked flag), and card_func is never masked. With tie at 1 (control bit 0), csc_irq is held low.
- R6: Clear-on-read mode (control bit 2 = 0). A read of address 0 clears exactly the flag bits that the read returned as 1. A write to address 0 has no effect.
- R7: Write-1 mode (control bit 2 = 1). A write to address 0 clears each flag whose wdata bit is 1. A read of address 0 has no side effect.
- R8: Newer-style flags clear only on a write to address 2, per wdata bit set to 1, in either mode. Reading them never changes them.
- R9: Register port. rdata takes the addressed value at the edge where rd_en is high and holds at other times. The control register (address 4) reads tie in bit 0, clear mode in bit 2 and the live card_func level in bit 7. Addresses 5 to 7 read 0. Unmapped write bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| leg_evt | input | N_LEG | Older-style event pulses |
| pwr_done | input | 1 | Power-up-complete pulse from the power logic |
| new_evt | input | N_NEW | Newer-style socket event pulses |
| card_func | input | 1 | Card functional interrupt level, unmasked |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| csc_irq | output | 1 | Card status change interrupt |
| func_irq | output | 1 | Functional interrupt line |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled synchronously. They also assume that rd_en and wr_en are never high in the same cycle, so that a read-side check is not confused by a write clear. The stimulus drives every input at the falling edge. It keeps reads and writes mutually exclusive, both in the directed sections and in the randomised section, and holds all pulses low while reset is asserted.

// File: rtl/sock_irq_pkg.sv
package sock_irq_pkg;

    // register addresses
    localparam int unsigned REG_LFLAG = 0;
    localparam int unsigned REG_LMASK = 1;
    localparam int unsigned REG_NFLAG = 2;
    localparam int unsigned REG_NMASK = 3;
    localparam int unsigned REG_CTRL  = 4;

    // control register bit positions
    localparam int unsigned CTRL_TIE     = 0;
    localparam int unsigned CTRL_CLRMODE = 2;
    localparam int unsigned CTRL_FUNC    = 7;

    typedef enum logic {
        CLR_ON_READ = 1'b0,
        CLR_ON_W1   = 1'b1
    } clr_mode_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned W      = 4,
    parameter bit          HAS_RC = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         w1c_i,
    input  logic [W-1:0] w1c_bits_i,
    input  logic         rc_i,
    output logic [W-1:0] flags_o
);

    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t        s_d, s_q;
    logic [W-1:0] rc_clr;
    logic [W-1:0] clr;

    generate
        if (HAS_RC) begin : g_rc
            // a read clears only what it returned: the current flag value
            assign rc_clr = rc_i ? s_q.flags : '0;
        end else begin : g_no_rc
            logic unused_rc;
            assign unused_rc = rc_i;
            assign rc_clr    = '0;
        end
    endgenerate

    always_comb begin
        s_d       = s_q;
        clr       = (w1c_i ? w1c_bits_i : '0) | rc_clr;
        // set is applied after clear so a coincident event survives
        s_d.flags = (s_q.flags & ~clr) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o = s_q.flags;

endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
    import sock_irq_pkg::*;
#(
    parameter int unsigned NL = 4,
    parameter int unsigned NN = 4,
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NL-1:0] leg_flags,
    input  logic [NN-1:0] new_flags,
    input  logic          card_func,
    output logic [DW-1:0] rdata,
    output logic [NL-1:0] leg_mask,
    output logic [NN-1:0] new_mask,
    output logic          tie,
    output logic          clr_w1,
    output logic          leg_w1c,
    output logic          leg_rc,
    output logic          new_w1c
);

    typedef struct packed {
        logic [NL-1:0] lmask;
        logic [NN-1:0] nmask;
        logic          tie;
        clr_mode_e     mode;
        logic [DW-1:0] rdata;
    } regs_t;

    regs_t         r_d, r_q;
    logic [DW-1:0] rd_val;
    logic          hit_lflag, hit_lmask, hit_nflag, hit_nmask, hit_ctrl;
    logic          unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        hit_lflag = (addr == AW'(REG_LFLAG));
        hit_lmask = (addr == AW'(REG_LMASK));
        hit_nflag = (addr == AW'(REG_NFLAG));
        hit_nmask = (addr == AW'(REG_NMASK));
        hit_ctrl  = (addr == AW'(REG_CTRL));
    end

    // read multiplexer, zero-extended
    always_comb begin
        rd_val = '0;
        if (hit_lflag) rd_val[NL-1:0] = leg_flags;
        if (hit_lmask) rd_val[NL-1:0] = r_q.lmask;
        if (hit_nflag) rd_val[NN-1:0] = new_flags;
        if (hit_nmask) rd_val[NN-1:0] = r_q.nmask;
        if (hit_ctrl) begin
            rd_val[CTRL_TIE]     = r_q.tie;
            rd_val[CTRL_CLRMODE] = r_q.mode;
            rd_val[CTRL_FUNC]    = card_func;
        end
    end

    always_comb begin
        r_d = r_q;
        if (rd_en) r_d.rdata = rd_val;
        if (wr_en) begin
            if (hit_lmask) r_d.lmask = wdata[NL-1:0];
            if (hit_nmask) r_d.nmask = wdata[NN-1:0];
            if (hit_ctrl) begin
                r_d.tie  = wdata[CTRL_TIE];
                r_d.mode = clr_mode_e'(wdata[CTRL_CLRMODE]);
            end
        end
    end

    // clear strobes toward the flag banks
    always_comb begin
        leg_w1c = wr_en && hit_lflag && (r_q.mode == CLR_ON_W1);
        leg_rc  = rd_en && hit_lflag && (r_q.mode == CLR_ON_READ);
        new_w1c = wr_en && hit_nflag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mode <= CLR_ON_READ;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata    = r_q.rdata;
    assign leg_mask = r_q.lmask;
    assign new_mask = r_q.nmask;
    assign tie      = r_q.tie;
    assign clr_w1   = (r_q.mode == CLR_ON_W1);

endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int unsigned NL = 4,
    parameter int unsigned NN = 4
) (
    input  logic [NL-1:0] leg_flags,
    input  logic [NL-1:0] leg_mask,
    input  logic [NN-1:0] new_flags,
    input  logic [NN-1:0] new_mask,
    input  logic          tie,
    input  logic          card_func,
    output logic          csc_irq,
    output logic          func_irq
);

    logic csc_any;

    always_comb begin
        csc_any  = (|(leg_flags & leg_mask)) | (|(new_flags & new_mask));
        csc_irq  = csc_any & ~tie;
        func_irq = card_func | (csc_any & tie);
    end

endmodule

// File: rtl/sock_irq_unit.sv
module sock_irq_unit #(
    parameter int unsigned N_LEG = 3,
    parameter int unsigned N_NEW = 4,
    parameter int unsigned DW    = 8,
    parameter int unsigned AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LEG-1:0] leg_evt,
    input  logic             pwr_done,
    input  logic [N_NEW-1:0] new_evt,
    input  logic             card_func,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             csc_irq,
    output logic             func_irq
);

    localparam int unsigned NL = N_LEG + 1;  // power-up-complete is the top bit
    localparam int unsigned NN = N_NEW;

    logic [NL-1:0] leg_set, leg_flags, leg_mask;
    logic [NN-1:0] new_flags, new_mask;
    logic          tie, clr_w1, leg_w1c, leg_rc, new_w1c;
    logic          unused_mode;

    assign leg_set     = {pwr_done, leg_evt};
    assign unused_mode = clr_w1;

    irq_reg_if #(.NL(NL), .NN(NN), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .leg_flags (leg_flags),
        .new_flags (new_flags),
        .card_func (card_func),
        .rdata     (rdata),
        .leg_mask  (leg_mask),
        .new_mask  (new_mask),
        .tie       (tie),
        .clr_w1    (clr_w1),
        .leg_w1c   (leg_w1c),
        .leg_rc    (leg_rc),
        .new_w1c   (new_w1c)
    );

    irq_flag_bank #(.W(NL), .HAS_RC(1'b1)) u_leg_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (leg_set),
        .w1c_i      (leg_w1c),
        .w1c_bits_i (wdata[NL-1:0]),
        .rc_i       (leg_rc),
        .flags_o    (leg_flags)
    );

    irq_flag_bank #(.W(NN), .HAS_RC(1'b0)) u_new_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (new_evt),
        .w1c_i      (new_w1c),
        .w1c_bits_i (wdata[NN-1:0]),
        .rc_i       (1'b0),
        .flags_o    (new_flags)
    );

    irq_router #(.NL(NL), .NN(NN)) u_route (
        .leg_flags (leg_flags),
        .leg_mask  (leg_mask),
        .new_flags (new_flags),
        .new_mask  (new_mask),
        .tie       (tie),
        .card_func (card_func),
        .csc_irq   (csc_irq),
        .func_irq  (func_irq)
    );

endmodule

// File: rtl/sock_irq_checker.sv
module sock_irq_checker #(
    parameter int unsigned NL = 4,
    parameter int unsigned NN = 4,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NL-1:0] leg_set,
    input logic [NL-1:0] leg_flags,
    input logic [NN-1:0] new_evt,
    input logic [NN-1:0] new_flags,
    input logic          tie,
    input logic          card_func,
    input logic          rd_en,
    input logic          wr_en,
    input logic [DW-1:0] rdata,
    input logic          csc_irq,
    input logic          func_irq
);

    // R3: an event always leaves its flag set, whatever clear coincides
    a_r3_leg_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|leg_set) |=> ((leg_flags & $past(leg_set)) == $past(leg_set)));

    a_r3_new_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|new_evt) |=> ((new_flags & $past(new_evt)) == $past(new_evt)));

    // R2: no flag rises without its event
    a_r2_leg_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((leg_flags & ~$past(leg_flags) & ~$past(leg_set)) == '0));

    a_r2_new_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((new_flags & ~$past(new_flags) & ~$past(new_evt)) == '0));

    // R5: tie silences the status-change line; the functional level is never blocked
    a_r5_tie_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tie |-> !csc_irq);

    a_r5_func_pass: assert property (@(posedge clk) disable iff (!rst_n)
        card_func |-> func_irq);

    // R8: reads never clear newer-style flags
    a_r8_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> ((new_flags & $past(new_flags)) == $past(new_flags)));

    // R9: read data only moves on a read
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind sock_irq_unit sock_irq_checker #(.NL(NL), .NN(NN), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .leg_set   (leg_set),
    .leg_flags (leg_flags),
    .new_evt   (new_evt),
    .new_flags (new_flags),
    .tie       (tie),
    .card_func (card_func),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rdata     (rdata),
    .csc_irq   (csc_irq),
    .func_irq  (func_irq)
);

// File: tb/tb_sock_irq_unit.sv
module tb_sock_irq_unit;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] leg_evt;
    logic       pwr_done;
    logic [3:0] new_evt;
    logic       card_func;
    logic       rd_en, wr_en;
    logic [2:0] addr;
    logic [7:0] wdata;
    wire  [7:0] rdata;
    wire        csc_irq, func_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    sock_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .leg_evt(leg_evt), .pwr_done(pwr_done),
        .new_evt(new_evt), .card_func(card_func), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .csc_irq(csc_irq),
        .func_irq(func_irq)
    );

    // behavioural reference state
    logic [3:0] m_lf, m_lm, m_nf, m_nm;
    logic       m_tie, m_w1;
    logic [7:0] m_rd;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag   = "R1";

    task automatic model_reset();
        m_lf = '0; m_lm = '0; m_nf = '0; m_nm = '0;
        m_tie = 1'b0; m_w1 = 1'b0; m_rd = '0;
    endtask

    task automatic model_step();
        logic [3:0] lset, lclr, nclr;
        lset = {pwr_done, leg_evt};
        lclr = '0;
        nclr = '0;
        if (wr_en && addr == 3'd0 && m_w1)  lclr = wdata[3:0];
        if (rd_en && addr == 3'd0 && !m_w1) lclr = m_lf;
        if (wr_en && addr == 3'd2)          nclr = wdata[3:0];
        if (rd_en) begin
            case (addr)
                3'd0:    m_rd = {4'h0, m_lf};
                3'd1:    m_rd = {4'h0, m_lm};
                3'd2:    m_rd = {4'h0, m_nf};
                3'd3:    m_rd = {4'h0, m_nm};
                3'd4:    m_rd = {card_func, 4'h0, m_w1, 1'b0, m_tie};
                default: m_rd = 8'h00;
            endcase
        end
        if (wr_en) begin
            if (addr == 3'd1) m_lm = wdata[3:0];
            if (addr == 3'd3) m_nm = wdata[3:0];
            if (addr == 3'd4) begin
                m_tie = wdata[0];
                m_w1  = wdata[2];
            end
        end
        m_lf = (m_lf & ~lclr) | lset;
        m_nf = (m_nf & ~nclr) | new_evt;
    endtask

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic any;
        any = (|(m_lf & m_lm)) || (|(m_nf & m_nm));
        check("csc_irq (R4)",  {7'h0, csc_irq},  {7'h0, any && !m_tie});
        check("func_irq (R5)", {7'h0, func_irq}, {7'h0, card_func || (m_tie && any)});
        check("rdata (R9)",    rdata,            m_rd);
    endtask

    task automatic cyc();
        @(posedge clk);
        if (rst_n) model_step();
        else       model_reset();
        @(negedge clk);
        compare_all();
        leg_evt = '0; pwr_done = 1'b0; new_evt = '0; rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        addr = a; rd_en = 1'b1; cyc();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1; cyc();
    endtask

    task automatic fire(input logic [2:0] l, input logic p, input logic [3:0] n);
        leg_evt = l; pwr_done = p; new_evt = n; cyc();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; leg_evt = '0; pwr_done = 1'b0; new_evt = '0;
        card_func = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        model_reset();
        repeat (3) cyc();
        rst_n = 1'b1;

        // R1: reset values through the register port
        tag = "R1";
        cyc();
        for (int a = 0; a < 5; a++) rd(3'(a));

        // R2: every source captured and sticky
        tag = "R2";
        fire(3'b001, 1'b0, 4'h0);
        fire(3'b010, 1'b0, 4'h0);
        fire(3'b100, 1'b0, 4'h0);
        fire(3'b000, 1'b1, 4'h0);
        fire(3'b000, 1'b0, 4'h5);
        fire(3'b000, 1'b0, 4'hA);
        repeat (3) cyc();
        rd(3'd0);
        rd(3'd2);
        wr(3'd2, 8'h0F);

        // R4: masked and unmasked sources
        tag = "R4";
        wr(3'd1, 8'h05);
        wr(3'd3, 8'h02);
        fire(3'b010, 1'b0, 4'h0);
        cyc();
        fire(3'b001, 1'b0, 4'h0);
        cyc();
        rd(3'd0);
        fire(3'b000, 1'b0, 4'h2);
        cyc();
        wr(3'd2, 8'h02);
        fire(3'b000, 1'b1, 4'h0);
        wr(3'd1, 8'h08);
        rd(3'd0);

        // R5: functional passthrough and tie
        tag = "R5";
        card_func = 1'b1;
        cyc();
        wr(3'd4, 8'h01);
        fire(3'b000, 1'b0, 4'h2);
        card_func = 1'b0;
        cyc();
        rd(3'd4);
        card_func = 1'b1;
        rd(3'd4);
        card_func = 1'b0;
        wr(3'd2, 8'h02);
        wr(3'd4, 8'h00);
        cyc();

        // R6: clear-on-read mode
        tag = "R6";
        wr(3'd1, 8'h0F);
        fire(3'b011, 1'b0, 4'h0);
        wr(3'd0, 8'h0F);
        rd(3'd0);
        rd(3'd0);
        fire(3'b100, 1'b0, 4'h0);
        tag = "R3";
        addr = 3'd0; rd_en = 1'b1; leg_evt = 3'b101; cyc();
        rd(3'd0);
        rd(3'd0);

        // R7: write-1 mode
        tag = "R7";
        wr(3'd4, 8'h04);
        fire(3'b111, 1'b1, 4'h0);
        rd(3'd0);
        rd(3'd0);
        wr(3'd0, 8'h05);
        rd(3'd0);
        tag = "R3";
        addr = 3'd0; wdata = 8'h0A; wr_en = 1'b1; leg_evt = 3'b010; cyc();
        rd(3'd0);
        wr(3'd0, 8'h0F);

        // R8: newer-style flags in both modes
        tag = "R8";
        wr(3'd3, 8'h0F);
        fire(3'b000, 1'b0, 4'hF);
        rd(3'd2);
        rd(3'd2);
        wr(3'd0, 8'h0F);
        rd(3'd2);
        wr(3'd2, 8'h03);
        rd(3'd2);
        wr(3'd4, 8'h00);
        rd(3'd2);
        tag = "R3";
        addr = 3'd2; wdata = 8'h0C; wr_en = 1'b1; new_evt = 4'h4; cyc();
        rd(3'd2);
        wr(3'd2, 8'h0F);

        // R9: register map details
        tag = "R9";
        for (int a = 5; a < 8; a++) rd(3'(a));
        wr(3'd4, 8'hFF);
        rd(3'd4);
        wr(3'd1, 8'hFF);
        rd(3'd1);
        wr(3'd3, 8'hF0);
        rd(3'd3);
        wr(3'd4, 8'h00);
        rd(3'd4);
        cyc();

        // mixed randomised traffic
        tag = "mix";
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 9);
            leg_evt  = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
            pwr_done = ($urandom_range(0, 7) == 0);
            new_evt  = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
            if ($urandom_range(0, 15) == 0) card_func = ~card_func;
            addr  = 3'($urandom);
            wdata = 8'($urandom);
            if (op < 3)      rd_en = 1'b1;
            else if (op < 5) wr_en = 1'b1;
            cyc();
        end

        finish_run();
    end

endmodule